// File: doc/BRIEF.md
# Per-Area Bus Read Wait-State Controller

This block sets how many bus states each read cycle lasts when the address space is split into eight areas. A 16-bit control register holds one read-wait enable bit per area in its upper byte. A read request carries a 3-bit area number and two flags: one saying that the target is on-chip memory, and one saying that area 6 is used as a multiplexed address/data I/O space. From these, the enable bit, a long-wait count supplied by a separate register, and the active-low WAIT input, the block drives a cycle-active level and a one-clock cycle-done strobe.

The enable bit of area 1, which is the DRAM area, also sets two registered outputs. The first selects a short or long column-address phase. The second gives the wait count that a CBR refresh cycle inserts, taken from a 2-bit refresh-wait field.

WAIT is sampled at the clock edge that would otherwise enter the final state of a cycle. Each low sample puts in one more state, and WAIT is sampled again at the end of that added state.

Top module: `area_wait_ctl`

## Requirements
- R1: After reset the control register reads 0xFFFF. A write changes bits 15..8 (enable of area n at bit 8+n) and bit 1. Bits 7..2 and bit 0 always read 1. Without a write the register keeps its value.
- R2: A read with the on-chip flag set to areas 0 or 7 lasts 1 state, whatever the enable bit and WAIT are.
- R3: A read with the on-chip flag set to area 5 lasts 3 states, whatever the enable bit and WAIT are.
- R4: An external read of areas 1, 3, 4, 5 or 7 with the area's enable bit at 0 lasts 1 state, and WAIT is ignored. The on-chip flag has no effect on areas 1, 2, 3, 4 and 6.
- R5: An external read of areas 1, 3, 4, 5 or 7 with the enable bit at 1 lasts 2 states plus the WAIT-added states.
- R6: A read of areas 0, 2 or 6 (external, and not multiplexed for area 6) with the enable bit at 0 lasts 1 + long-wait states, and WAIT is ignored.
- R7: The same reads with the enable bit at 1 last 1 + long-wait states plus the WAIT-added states.
- R8: A read of area 6 with the multiplexed flag set lasts 4 states plus the WAIT-added states, whatever the enable bit is.
- R9: When sampling is enabled, WAIT is sampled at each edge that would enter the final state. A sampled 0 adds one state, and WAIT is sampled again at the next edge.
- R10: A request is accepted only while cyc_active is 0, and cyc_active is 0 after reset. cyc_active rises on the edge that accepts the request and stays high through the final state. cyc_done is high for exactly the one clock of the final state. A request made while cyc_active is 1 is ignored. The enable bits are taken as they stand at the accepting edge.
- R11: dram_long_pitch equals the area 1 enable bit, delayed by one clock. It is 1 after reset.
- R12: cbr_wait equals the refresh-wait field when the area 1 enable bit was 1 on the previous clock, and 0 otherwise. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register value |
| rd_req | input | 1 | Read request |
| rd_area | input | 3 | Area number of the request |
| rd_onchip | input | 1 | Target is on-chip memory |
| rd_muxio | input | 1 | Area 6 used as multiplexed address/data I/O |
| wait_n | input | 1 | Active-low WAIT input |
| long_wait | input | LW_W | Long-wait count |
| rfsh_wait_sel | input | 2 | Refresh-wait field |
| cyc_active | output | 1 | Read cycle in progress |
| cyc_done | output | 1 | Final state of the cycle |
| dram_long_pitch | output | 1 | Long column-address phase selected |
| cbr_wait | output | 2 | Wait count for a CBR refresh |

## Verification
Every combination of area, on-chip flag, multiplexed flag, long-wait count and enable-byte pattern is run with WAIT held high, toggling at random, and mostly low. Holding WAIT high exposes the base lengths and whether the long-wait count is added. The random and mostly-low patterns show which rules sample WAIT and which ignore it. A directed run with requests held high separates acceptance while idle from requests ignored during a cycle. Writes to the register that change the area 1 bit, together with a changing refresh field, check the pitch and refresh-wait outputs.

// File: rtl/awc_pkg.sv
package awc_pkg;
  localparam int CFG_W      = 16;
  localparam int AREA_W     = 3;
  localparam int N_AREAS    = 1 << AREA_W;
  localparam logic [CFG_W-1:0] CFG_RST = 16'hFFFF;
  localparam logic [AREA_W-1:0] A_ROM    = 3'd0;
  localparam logic [AREA_W-1:0] A_DRAM   = 3'd1;
  localparam logic [AREA_W-1:0] A_NORM2  = 3'd2;
  localparam logic [AREA_W-1:0] A_PERIPH = 3'd5;
  localparam logic [AREA_W-1:0] A_MUXIO  = 3'd6;
  localparam logic [AREA_W-1:0] A_RAM    = 3'd7;
  localparam int PERIPH_LEN = 3;
  localparam int MUXIO_LEN  = 4;
  localparam int WIDE_LEN   = 2;
endpackage

// File: rtl/awc_cfg_reg.sv
module awc_cfg_reg
  import awc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata
);
  logic [N_AREAS-1:0] en_q;
  logic               ww_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= CFG_RST[CFG_W-1 -: N_AREAS];
      ww_q <= CFG_RST[1];
    end else if (we) begin
      en_q <= wdata[CFG_W-1 -: N_AREAS];
      ww_q <= wdata[1];
    end
  end

  assign rdata = {en_q, 6'h3F, ww_q, 1'b1};

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata));
endmodule

// File: rtl/awc_rule_decode.sv
module awc_rule_decode
  import awc_pkg::*;
#(
  parameter int LW_W  = 2,
  parameter int CNT_W = 3
)(
  input  logic [AREA_W-1:0]  area,
  input  logic               onchip,
  input  logic               muxio,
  input  logic [N_AREAS-1:0] en_bits,
  input  logic [LW_W-1:0]    long_wait,
  output logic [CNT_W-1:0]   base_len,
  output logic               sample_wait
);
  logic en_bit;
  logic lw_area;
  assign en_bit  = en_bits[area];
  assign lw_area = (area == A_ROM) || (area == A_NORM2) || (area == A_MUXIO);

  always_comb begin
    if (onchip && (area == A_ROM || area == A_RAM)) begin
      base_len    = CNT_W'(1);
      sample_wait = 1'b0;
    end else if (onchip && area == A_PERIPH) begin
      base_len    = CNT_W'(PERIPH_LEN);
      sample_wait = 1'b0;
    end else if (muxio && area == A_MUXIO) begin
      base_len    = CNT_W'(MUXIO_LEN);
      sample_wait = 1'b1;
    end else if (lw_area) begin
      base_len    = CNT_W'(1) + CNT_W'(long_wait);
      sample_wait = en_bit;
    end else begin
      base_len    = en_bit ? CNT_W'(WIDE_LEN) : CNT_W'(1);
      sample_wait = en_bit;
    end
  end
endmodule

// File: rtl/awc_cycle_seq.sv
module awc_cycle_seq #(
  parameter int CNT_W = 3
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CNT_W-1:0] base_len,
  input  logic             sample_wait,
  input  logic             wait_n,
  output logic             active,
  output logic             done
);
  logic [CNT_W-1:0] rem_q, rem_in;
  logic             samp_q, samp_in;
  logic             accept, step;

  assign accept  = req && !active;
  assign rem_in  = accept ? base_len : rem_q;
  assign samp_in = accept ? sample_wait : samp_q;
  assign step    = accept || (active && !done);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      done   <= 1'b0;
      rem_q  <= '0;
      samp_q <= 1'b0;
    end else if (step) begin
      active <= 1'b1;
      samp_q <= samp_in;
      if (rem_in == CNT_W'(1)) begin
        if (samp_in && !wait_n) begin
          done  <= 1'b0;
          rem_q <= CNT_W'(1);
        end else begin
          done  <= 1'b1;
          rem_q <= '0;
        end
      end else begin
        done  <= 1'b0;
        rem_q <= rem_in - CNT_W'(1);
      end
    end else if (done) begin
      active <= 1'b0;
      done   <= 1'b0;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  done_inside_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> active);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    active && !done |=> active);
  // R4
  one_state_chk: assert property (@(posedge clk) disable iff (rst)
    accept && base_len == CNT_W'(1) && !sample_wait |=> done);
  // R9
  wait_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    active && !done && rem_q == CNT_W'(1) && samp_q && !wait_n |=> !done);
endmodule

// File: rtl/area_wait_ctl.sv
module area_wait_ctl
  import awc_pkg::*;
#(
  parameter int LW_W = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             rd_req,
  input  logic [2:0]       rd_area,
  input  logic             rd_onchip,
  input  logic             rd_muxio,
  input  logic             wait_n,
  input  logic [LW_W-1:0]  long_wait,
  input  logic [1:0]       rfsh_wait_sel,
  output logic             cyc_active,
  output logic             cyc_done,
  output logic             dram_long_pitch,
  output logic [1:0]       cbr_wait
);
  localparam int LW_LEN  = 1 << LW_W;
  localparam int MAX_LEN = (LW_LEN > MUXIO_LEN) ? LW_LEN : MUXIO_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [N_AREAS-1:0] en_bits;
  logic [CNT_W-1:0]   base_len;
  logic               sample_wait;

  awc_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata)
  );

  assign en_bits = cfg_rdata[CFG_W-1 -: N_AREAS];

  awc_rule_decode #(.LW_W(LW_W), .CNT_W(CNT_W)) u_rule (
    .area(rd_area), .onchip(rd_onchip), .muxio(rd_muxio), .en_bits(en_bits),
    .long_wait(long_wait), .base_len(base_len), .sample_wait(sample_wait)
  );

  awc_cycle_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .req(rd_req), .base_len(base_len),
    .sample_wait(sample_wait), .wait_n(wait_n),
    .active(cyc_active), .done(cyc_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_long_pitch <= 1'b1;
      cbr_wait        <= 2'd0;
    end else begin
      dram_long_pitch <= en_bits[A_DRAM];
      cbr_wait        <= en_bits[A_DRAM] ? rfsh_wait_sel : 2'd0;
    end
  end

  // R11
  pitch_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dram_long_pitch == $past(cfg_rdata[8 + int'(A_DRAM)]));
  // R12
  cbr_short_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_long_pitch |-> cbr_wait == 2'd0);
endmodule

// File: tb/area_wait_ctl_bench.sv
module area_wait_ctl_bench;
  localparam int CLK_P = 10;
  localparam int LW_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic rd_req = 1'b0;
  logic [2:0] rd_area = '0;
  logic rd_onchip = 1'b0, rd_muxio = 1'b0, wait_n = 1'b1;
  logic [LW_W-1:0] long_wait = '0;
  logic [1:0] rfsh_wait_sel = '0;
  logic cyc_active, cyc_done, dram_long_pitch;
  logic [1:0] cbr_wait;

  area_wait_ctl #(.LW_W(LW_W)) u_area_wait_ctl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rd_req(rd_req), .rd_area(rd_area),
    .rd_onchip(rd_onchip), .rd_muxio(rd_muxio), .wait_n(wait_n),
    .long_wait(long_wait), .rfsh_wait_sel(rfsh_wait_sel),
    .cyc_active(cyc_active), .cyc_done(cyc_done),
    .dram_long_pitch(dram_long_pitch), .cbr_wait(cbr_wait)
  );

  always #(CLK_P/2) clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  string tag = "R10";
  bit armed = 0;
  int wait_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  logic [15:0] m_reg;
  int m_phase;   // 0 idle, 1 running, 2 final state
  int m_left;
  bit m_samp;
  bit m_pitch;
  int m_cbr;

  function automatic int ref_len(int a, bit onc, bit mx, bit en, int lw, output bit smp);
    smp = 0;
    case (a)
      0: if (onc) return 1; else begin smp = en; return 1 + lw; end
      7: if (onc) return 1; else begin smp = en; return en ? 2 : 1; end
      5: if (onc) return 3; else begin smp = en; return en ? 2 : 1; end
      6: if (mx) begin smp = 1; return 4; end
         else begin smp = en; return 1 + lw; end
      2: begin smp = en; return 1 + lw; end
      default: begin smp = en; return en ? 2 : 1; end
    endcase
  endfunction

  function automatic string rule_tag(int a, bit onc, bit mx, bit en);
    if (onc && (a == 0 || a == 7)) return "R2";
    if (onc && a == 5) return "R3";
    if (a == 6 && mx) return "R8";
    if (a == 0 || a == 2 || a == 6) return en ? "R7" : "R6";
    return en ? "R5" : "R4";
  endfunction

  task automatic m_advance();
    if (m_left == 1) begin
      if (m_samp && !wait_n) m_phase = 1;
      else begin m_phase = 2; m_left = 0; end
    end else begin
      m_left = m_left - 1;
      m_phase = 1;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    armed = 1;
    if (rst) begin
      m_reg = 16'hFFFF; m_phase = 0; m_left = 0; m_samp = 0;
      m_pitch = 1; m_cbr = 0;
    end else begin
      m_pitch = m_reg[9];
      m_cbr = m_reg[9] ? int'(rfsh_wait_sel) : 0;
      if (m_phase == 0) begin
        if (rd_req) begin
          bit s;
          m_left = ref_len(int'(rd_area), rd_onchip, rd_muxio,
                           m_reg[8 + int'(rd_area)], int'(long_wait), s);
          m_samp = s;
          m_advance();
        end
      end else if (m_phase == 2) begin
        m_phase = 0;
      end else begin
        m_advance();
      end
      if (cfg_we) m_reg = {cfg_wdata[15:8], 6'h3F, cfg_wdata[1], 1'b1};
    end
  end

  task automatic cmp(string t, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", t, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      cmp("R1", int'(cfg_rdata), int'(m_reg), "cfg_rdata");
      cmp(tag, int'(cyc_active), (m_phase != 0) ? 1 : 0, "cyc_active");
      cmp(tag, int'(cyc_done), (m_phase == 2) ? 1 : 0, "cyc_done");
      cmp("R11", int'(dram_long_pitch), int'(m_pitch), "dram_long_pitch");
      cmp("R12", int'(cbr_wait), m_cbr, "cbr_wait");
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (wait_mode)
      0: wait_n = 1'b1;
      1: wait_n = lfsr[0];
      default: wait_n = lfsr[0] & lfsr[3];
    endcase
  end

  task automatic write_cfg(logic [15:0] d);
    @(negedge clk);
    tag = "R1";
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    for (int g = 0; g < 200 && (m_phase != 0 || cyc_active); g++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] en_pat [3];
    en_pat[0] = 8'h00; en_pat[1] = 8'hFF; en_pat[2] = 8'hA5;
    repeat (3) @(negedge clk);
    tag = "R10";   // R10 reset state
    rst = 1'b0;
    @(negedge clk);
    // R1 low byte: only bit 1 writable
    write_cfg(16'h0000);
    write_cfg(16'hFF02);
    for (int p = 0; p < 3; p++) begin
      write_cfg({en_pat[p], 8'h00});
      for (int a = 0; a < 8; a++)
        for (int oc = 0; oc < 2; oc++)
          for (int mx = 0; mx < 2; mx++)
            for (int lw = 0; lw < 4; lw++)
              for (int wm = 0; wm < 3; wm++) begin
                @(negedge clk);
                rd_area = 3'(a); rd_onchip = oc[0]; rd_muxio = mx[0];
                long_wait = LW_W'(lw); wait_mode = wm;
                rfsh_wait_sel = 2'(lw + a);
                tag = (wm != 0 && en_pat[p][a]) ? "R9" : rule_tag(a, oc[0], mx[0], en_pat[p][a]);
                rd_req = 1'b1;
                @(negedge clk);
                rd_req = 1'b0;
                drain();
              end
    end
    // R10: requests held high, back to back, during register updates
    tag = "R10";
    wait_mode = 1;
    rd_req = 1'b1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      rd_area = 3'(k % 8); rd_onchip = k[1]; rd_muxio = k[2];
      cfg_we = (k % 7 == 0); cfg_wdata = {8'(k * 37), 8'(k)};
      rfsh_wait_sel = 2'(k);
    end
    @(negedge clk);
    rd_req = 1'b0; cfg_we = 1'b0;
    drain();
    // R12: area 1 bit cleared forces zero refresh wait
    write_cfg(16'h00FF);
    rfsh_wait_sel = 2'd3;
    repeat (3) @(negedge clk);
    write_cfg(16'h0200);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    mismatched++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule